// File: doc/BRIEF.md
# Paged Write Buffer with Timed Commit

This block sits between the serial protocol engine and the storage array of a small byte-wide nonvolatile memory model. A transaction begins with a start strobe that loads a word address. Each data byte that follows is captured into a buffer of one page. The in-page offset advances after every byte and wraps inside the page. The page number, which is the upper address bits, stays fixed for the whole transaction. If more bytes arrive than the page holds, the later bytes land on the same slots and replace the earlier ones, so only the most recent page's worth survives.

Nothing reaches the array until a stop strobe arrives. The stop starts a self-timed write cycle, and a busy flag then stays high for a parameterized number of clocks. In the first cycles of that window the block walks the buffer slots in ascending offset order and drives the array write port. It writes only the slots that were loaded, and only at addresses that the protection logic currently allows. The full busy window is served even when every byte is refused. While busy, the block ignores new starts, bytes and stops. A one-cycle done pulse marks the end of the window. A stop that arrives before any byte was buffered starts no cycle.

Top module: `paged_write_buffer`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `mem_we_o` are all low.
- R2: No array write takes place while bytes are being collected. Writes happen only after a stop strobe has been accepted.
- R3: Byte k of a transaction (k = 0, 1, ...) with start address A is written to address {A[7:4], (A[3:0] + k) mod 16}. The upper four bits never change inside a transaction.
- R4: When more than 16 bytes are sent, each slot keeps the last byte sent to it. Earlier bytes for that slot are lost.
- R5: Array locations whose buffer slot was not loaded in the transaction keep their previous contents.
- R6: A location is written only when `mem_allow_i` is high for its address in the cycle that `mem_we_o` is raised. A refused location keeps its contents.
- R7: After an accepted stop with at least one buffered byte, `busy_o` rises on the next clock and stays high for exactly `WC_CYCLES` cycles, even when every write was refused.
- R8: `done_o` is high for exactly one cycle, which is the first cycle in which `busy_o` is low again after a write cycle.
- R9: A stop strobe with no buffered byte raises neither `busy_o` nor `mem_we_o`.
- R10: While `busy_o` is high, `start_i`, `byte_vld_i` and `stop_i` have no effect. The cycle is not lengthened, and the array and the next transaction are not affected.
- R11: Commit writes are issued one per cycle, in strictly ascending address order within the page, and only while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transaction and load `start_addr_i`; clears the buffer |
| start_addr_i | input | ADDR_W | Word address of the first byte |
| byte_vld_i | input | 1 | One data byte is present on `byte_i` |
| byte_i | input | DATA_W | Data byte |
| stop_i | input | 1 | End of transaction; launches the write cycle if any byte was buffered |
| mem_allow_i | input | 1 | Protection verdict for the address on `mem_addr_o` |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Self-timed write cycle in progress |
| done_o | output | 1 | One-cycle pulse when the write cycle ends |

## Verification
The bench sweeps four start addresses, seven byte counts and three protection maps. The start addresses are a page base, mid-page offsets and the last slot of a page. The byte counts are 1, 2, 15, 16, 17, 31 and 40. The protection maps are none, the lower half of the address space, and everything. The bench compares the whole array against an arithmetic model after each trial.

Short runs that start near the end of a page separate in-page wrap from a carry into the page bits. Counts above 16 separate overwrite of a slot from appending past it. The fully protected map separates a write cycle of full length from one that is skipped. Extra runs inject stimulus while the block is busy and send stops with an empty buffer, which shows whether stale buffer state or a stray stop can leak into a later cycle.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    // Control phase of the buffer front end.
    typedef enum logic {
        PH_OPEN   = 1'b0,  // collecting bytes, or idle
        PH_COMMIT = 1'b1   // walking buffer slots into the array
    } pwb_phase_e;
endpackage

// File: rtl/pwb_addr_ptr.sv
module pwb_addr_ptr #(
    parameter int ADDR_W = 8,
    parameter int OFS_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic [ADDR_W-1:0]        load_addr_i,
    input  logic                     inc_i,
    output logic [ADDR_W-OFS_W-1:0]  page_o,
    output logic [OFS_W-1:0]         off_o
);
    localparam int PAGE_W = ADDR_W - OFS_W;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [OFS_W-1:0]  off;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load_i) begin
            ptr_d.page = load_addr_i[ADDR_W-1:OFS_W];
            ptr_d.off  = load_addr_i[OFS_W-1:0];
        end else if (inc_i) begin
            // natural wrap of the offset keeps the pointer inside its page
            ptr_d.off = ptr_q.off + OFS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign page_o = ptr_q.page;
    assign off_o  = ptr_q.off;
endmodule

// File: rtl/pwb_slot_store.sv
module pwb_slot_store #(
    parameter int SLOTS  = 16,
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr_i,
    input  logic                       wr_i,
    input  logic [$clog2(SLOTS)-1:0]   wr_idx_i,
    input  logic [DATA_W-1:0]          wr_data_i,
    input  logic [$clog2(SLOTS)-1:0]   rd_idx_i,
    output logic [DATA_W-1:0]          rd_data_o,
    output logic                       rd_vld_o,
    output logic                       any_vld_o
);
    localparam int IDX_W = $clog2(SLOTS);

    logic [SLOTS-1:0]  vld_vec;
    logic [DATA_W-1:0] data_arr [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        typedef struct packed {
            logic              vld;
            logic [DATA_W-1:0] data;
        } slot_t;

        slot_t slot_d, slot_q;
        logic  hit;

        assign hit = wr_i && (wr_idx_i == IDX_W'(g));

        always_comb begin
            slot_d = slot_q;
            if (clr_i) begin
                slot_d.vld = 1'b0;
            end else if (hit) begin
                // a later byte to the same slot replaces the earlier one
                slot_d.vld  = 1'b1;
                slot_d.data = wr_data_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign vld_vec[g]  = slot_q.vld;
        assign data_arr[g] = slot_q.data;
    end

    assign rd_data_o = data_arr[rd_idx_i];
    assign rd_vld_o  = vld_vec[rd_idx_i];
    assign any_vld_o = |vld_vec;
endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
    parameter int WC_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(WC_CYCLES + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] left;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d      = tmr_q;
        tmr_d.done = 1'b0;
        if (tmr_q.busy) begin
            if (tmr_q.left == '0) begin
                tmr_d.busy = 1'b0;
                tmr_d.done = 1'b1;
            end else begin
                tmr_d.left = tmr_q.left - CNT_W'(1);
            end
        end else if (launch_i) begin
            tmr_d.busy = 1'b1;
            tmr_d.left = CNT_W'(WC_CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy_o = tmr_q.busy;
    assign done_o = tmr_q.done;
endmodule

// File: rtl/paged_write_buffer.sv
module paged_write_buffer
    import pwb_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16,
    parameter int WC_CYCLES  = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              stop_i,
    input  logic              mem_allow_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam logic [OFS_W-1:0] LAST_IDX = OFS_W'(PAGE_BYTES - 1);

    if ((1 << OFS_W) != PAGE_BYTES) begin : g_bad_page
        $error("PAGE_BYTES must be a power of two");
    end
    if (WC_CYCLES < PAGE_BYTES) begin : g_bad_cycle
        $error("WC_CYCLES must cover one pass over the page");
    end

    typedef struct packed {
        pwb_phase_e       phase;
        logic [OFS_W-1:0] idx;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [PAGE_W-1:0] cur_page;
    logic [OFS_W-1:0]  cur_off;
    logic              store_any_vld;
    logic              slot_vld;
    logic [DATA_W-1:0] slot_data;
    logic              accept, do_load, do_take, do_launch, in_commit, store_clr;

    // Front-end decisions; start wins over stop, stop wins over a byte.
    always_comb begin
        accept    = !busy_o && (ctl_q.phase == PH_OPEN);
        do_load   = accept && start_i;
        do_launch = accept && !start_i && stop_i && store_any_vld;
        do_take   = accept && !start_i && !stop_i && byte_vld_i;
        in_commit = (ctl_q.phase == PH_COMMIT);
        store_clr = do_load || (in_commit && ctl_q.idx == LAST_IDX);
    end

    always_comb begin
        ctl_d = ctl_q;
        if (do_launch) begin
            ctl_d.phase = PH_COMMIT;
            ctl_d.idx   = '0;
        end else if (in_commit) begin
            ctl_d.idx = ctl_q.idx + OFS_W'(1);
            if (ctl_q.idx == LAST_IDX) ctl_d.phase = PH_OPEN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{phase: PH_OPEN, idx: '0};
        else        ctl_q <= ctl_d;
    end

    pwb_addr_ptr #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W)
    ) ptr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (do_load),
        .load_addr_i (start_addr_i),
        .inc_i       (do_take),
        .page_o      (cur_page),
        .off_o       (cur_off)
    );

    pwb_slot_store #(
        .SLOTS  (PAGE_BYTES),
        .DATA_W (DATA_W)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (store_clr),
        .wr_i      (do_take),
        .wr_idx_i  (cur_off),
        .wr_data_i (byte_i),
        .rd_idx_i  (ctl_q.idx),
        .rd_data_o (slot_data),
        .rd_vld_o  (slot_vld),
        .any_vld_o (store_any_vld)
    );

    pwb_cycle_timer #(
        .WC_CYCLES (WC_CYCLES)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (do_launch),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    assign mem_we_o    = in_commit && slot_vld && mem_allow_i;
    assign mem_addr_o  = {cur_page, ctl_q.idx};
    assign mem_wdata_o = slot_data;
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
    parameter int WC_CYCLES = 250000
) (
    input logic clk,
    input logic rst_n,
    input logic stop_i,
    input logic start_i,
    input logic mem_allow_i,
    input logic mem_we_o,
    input logic busy_o,
    input logic done_o,
    input logic store_any_vld
);
    int unsigned busy_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      busy_run_q <= 0;
        else if (busy_o) busy_run_q <= busy_run_q + 1;
        else             busy_run_q <= 0;
    end

    assert_we_in_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);

    assert_we_allowed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> mem_allow_i);

    assert_done_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    assert_empty_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i && !busy_o && !store_any_vld) |=> !busy_o);

    assert_busy_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (busy_run_q < WC_CYCLES));

    assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_run_q == WC_CYCLES));
endmodule

bind paged_write_buffer pwb_checker #(
    .WC_CYCLES (WC_CYCLES)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .stop_i        (stop_i),
    .start_i       (start_i),
    .mem_allow_i   (mem_allow_i),
    .mem_we_o      (mem_we_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .store_any_vld (store_any_vld)
);

// File: tb/paged_write_buffer_tb.sv
`timescale 1ns/1ps
module paged_write_buffer_tb_top;
    localparam int WC = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] start_addr_i = '0;
    logic       byte_vld_i = 1'b0;
    logic [7:0] byte_i = '0;
    logic       stop_i = 1'b0;
    logic       mem_allow_i;
    logic       mem_we_o;
    logic [7:0] mem_addr_o;
    logic [7:0] mem_wdata_o;
    logic       busy_o;
    logic       done_o;

    int prot_mode = 0;  // 0: none, 1: lower half refused, 2: all refused
    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0] mem [256];
    logic [7:0] expm [256];

    int busy_cnt, done_cnt, we_cnt, order_err;
    int last_addr;

    always #10 clk = ~clk;

    assign mem_allow_i = (prot_mode == 0) || (prot_mode == 1 && mem_addr_o[7]);

    paged_write_buffer #(
        .ADDR_W(8), .DATA_W(8), .PAGE_BYTES(16), .WC_CYCLES(WC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i), .stop_i(stop_i),
        .mem_allow_i(mem_allow_i), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .busy_o(busy_o), .done_o(done_o)
    );

    // Array model and write-order monitor.
    always @(posedge clk) begin
        if (rst_n && mem_we_o) begin
            mem[mem_addr_o] <= mem_wdata_o;
            we_cnt = we_cnt + 1;
            if (!busy_o) order_err = order_err + 1;
            if (last_addr >= 0 && int'(mem_addr_o) <= last_addr) order_err = order_err + 1;
            last_addr = int'(mem_addr_o);
        end
    end

    always @(negedge clk) begin
        if (busy_o) busy_cnt = busy_cnt + 1;
        if (done_o) done_cnt = done_cnt + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit allowed(input int a);
        return (prot_mode == 0) || (prot_mode == 1 && a >= 128);
    endfunction

    task automatic clear_counts();
        busy_cnt = 0; done_cnt = 0; we_cnt = 0; order_err = 0; last_addr = -1;
    endtask

    task automatic send_start(input logic [7:0] a);
        start_i = 1'b1; start_addr_i = a;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        byte_vld_i = 1'b1; byte_i = d;
        @(negedge clk);
        byte_vld_i = 1'b0;
    endtask

    task automatic send_stop();
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 200 && busy_o; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    function automatic int mismatches();
        int m = 0;
        for (int a = 0; a < 256; a++) if (mem[a] !== expm[a]) m++;
        return m;
    endfunction

    // One page transaction with an arithmetic expectation.
    task automatic trial(input int s, input int n, input bit poke_busy);
        int a;
        logic [7:0] d;
        for (int k = 0; k < 256; k++) expm[k] = mem[k];
        clear_counts();
        send_start(8'(s));
        for (int i = 0; i < n; i++) begin
            d = 8'(s * 3 + i * 29 + n * 11 + prot_mode * 5 + 1);
            a = (s & 8'hF0) | ((s + i) & 15);
            if (allowed(a)) expm[a] = d;
            send_byte(d);
        end
        chk(we_cnt == 0, "R2 no write before stop", we_cnt, 0);
        send_stop();
        if (poke_busy) begin
            repeat (20) @(negedge clk);
            send_start(8'h05 ^ 8'(s));
            send_byte(8'hEE);
            send_byte(8'hDD);
            send_stop();
        end
        wait_idle();
        chk(mismatches() == 0, $sformatf("R3 R4 R5 R6 array s=%0d n=%0d mode=%0d", s, n, prot_mode),
            mismatches(), 0);
        chk(busy_cnt == WC, "R7 busy length", busy_cnt, WC);
        chk(done_cnt == 1, "R8 done pulses", done_cnt, 1);
        chk(order_err == 0, "R11 write order", order_err, 0);
        if (poke_busy) chk(busy_cnt == WC && mismatches() == 0, "R10 busy ignores input", busy_cnt, WC);
    endtask

    initial begin
        int starts [4] = '{8'h00, 8'h37, 8'h8A, 8'hFF};
        int counts [7] = '{1, 2, 15, 16, 17, 31, 40};
        for (int a = 0; a < 256; a++) mem[a] = 8'(a) ^ 8'hA5;
        clear_counts();
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !mem_we_o, "R1 reset outputs", {busy_o, done_o, mem_we_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && !mem_we_o, "R1 after release", {busy_o, done_o, mem_we_o}, 0);

        // Empty stop, both bare and right after a start.
        clear_counts();
        send_stop();
        repeat (5) @(negedge clk);
        chk(busy_cnt == 0 && we_cnt == 0, "R9 bare stop", busy_cnt + we_cnt, 0);
        send_start(8'h42);
        send_stop();
        repeat (5) @(negedge clk);
        chk(busy_cnt == 0 && we_cnt == 0, "R9 stop after start", busy_cnt + we_cnt, 0);

        for (int m = 0; m < 3; m++) begin
            prot_mode = m;
            foreach (starts[i]) foreach (counts[j]) trial(starts[i], counts[j], 1'b0);
        end

        // Stimulus during busy is dropped and leaves no buffered state.
        prot_mode = 0;
        trial(8'h6C, 5, 1'b1);
        clear_counts();
        send_stop();
        repeat (5) @(negedge clk);
        chk(busy_cnt == 0 && we_cnt == 0, "R10 R9 no leftover after busy", busy_cnt + we_cnt, 0);

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule